// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the device side of a serial flash memory's four-wire interface. The serial clock, chip select and data input are synchronised into a faster system clock. Each transaction starts with a one-byte opcode. The block then collects any address, dummy and data bytes, most significant bit first. It returns status, identification or array read data on the serial output, and that output changes on falling serial clock edges.

The array itself lives in a back end behind three simple interfaces. The first is a read request with an address, answered by a valid pulse and a data byte. The second is a per-byte write stream that carries the address already wrapped inside its page. The third is a single-cycle command strobe, raised after chip select rises. The strobe carries an operation code, the 24-bit address and the count of data bytes. Write-type operations are committed only when chip select rises after a whole number of bytes. Operations that touch the array are dropped if the back end reports a cycle in progress when the opcode arrives.

Top module: `sflash_cmd_front`

## Requirements
- R1: Opcodes are decoded as follows. 0x06 write enable gives strobe code 1. 0x04 write disable gives code 2. 0x9F identification, 0x05 status and 0x03 read take no strobe, nor does 0x0B fast read. 0x0A page write gives code 7 and 0x02 page program gives code 8. 0xD8 sector erase gives code 10 and 0xDB page erase gives code 9. 0xB9 power-down gives code 11 and 0xAB wake-up gives code 12.
- R2: Input bits are taken most significant first on rising serial clock edges, and output bits change on falling edges. `miso_oe` is high only during an output phase, and it is low within a few system cycles of chip select rising.
- R3: After opcode 0x05, every output byte is the value of `stat_in`, repeated until chip select rises.
- R4: After opcode 0x9F, the output is the bytes of `ID_CODE` from the most significant byte down, then 0x00 from the fourth byte onward.
- R5: A command with a strobe code executes only if the number of serial clock pulses since chip select fell is a nonzero multiple of eight. The full header must also have arrived. Erases need at least 4 bytes, page write and page program need at least 5, and the rest need 1. Otherwise nothing is strobed.
- R6: `cmd_stb` is a one-cycle pulse that follows chip select rising. `cmd_addr` holds bytes 2 to 4 of the transaction, most significant byte first.
- R7: Read (0x03) requests bytes from the address given, then from each following address in turn. Fast read (0x0B) does the same after skipping one dummy byte. Chip select may rise at any bit, and this ends the read without a strobe.
- R8: Each page write or page program data byte k (counting from 0) gives one `wr_valid`. Its address keeps the upper 16 address bits and sets the low byte to the start byte plus k, modulo 256. `cmd_len` is the data byte count, held at 256 once it reaches it.
- R9: Read, fast read, page write, page program, page erase and sector erase are ignored if `busy` is high when their opcode completes. They then give no read request, no write, no strobe and no output enable. The other opcodes work as usual.
- R10: An unrecognised opcode gives no output enable, no request and no strobe until chip select rises.
- R11: After reset, `cmd_stb`, `rd_req`, `wr_valid` and `miso_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, idle low |
| csn | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso` |
| busy | input | 1 | Back end has a write, program or erase cycle in progress |
| stat_in | input | 8 | Status byte supplied by the back end |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 24 | Address of the read request |
| rd_valid | input | 1 | Read response valid |
| rd_data | input | 8 | Read response byte |
| wr_valid | output | 1 | One page data byte is available |
| wr_addr | output | 24 | Page-wrapped address of the data byte |
| wr_data | output | 8 | Data byte |
| cmd_stb | output | 1 | Committed command pulse |
| cmd_op | output | 4 | Strobe code (R1) |
| cmd_addr | output | 24 | Command address |
| cmd_len | output | 9 | Data byte count, held at 256 |

## Verification
The assertions assume that serial clock, chip select and data input change at least one synchroniser depth apart. Chip select never moves in the same few system cycles as a clock edge. They also assume the back end answers a read request well within half a serial clock period. The bench keeps half a serial period at eight system cycles and changes data only while the serial clock is low. It pauses a full half period around every chip select change and answers each read in the next system cycle. Under these conditions the order of synchronised events matches the order at the pins, which is what the boundary and strobe properties rely on.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int ADDR_W   = 24;
  localparam int LEN_W    = 9;
  localparam int PAGE_MAX = 256;

  typedef enum logic [3:0] {
    CMD_NONE  = 4'd0,
    CMD_WREN  = 4'd1,
    CMD_WRDI  = 4'd2,
    CMD_RDID  = 4'd3,
    CMD_RDSR  = 4'd4,
    CMD_READ  = 4'd5,
    CMD_FREAD = 4'd6,
    CMD_PW    = 4'd7,
    CMD_PP    = 4'd8,
    CMD_PE    = 4'd9,
    CMD_SE    = 4'd10,
    CMD_DP    = 4'd11,
    CMD_RDP   = 4'd12
  } cmd_e;

  function automatic cmd_e op_decode(input logic [7:0] b);
    case (b)
      8'h06:   return CMD_WREN;
      8'h04:   return CMD_WRDI;
      8'h9F:   return CMD_RDID;
      8'h05:   return CMD_RDSR;
      8'h03:   return CMD_READ;
      8'h0B:   return CMD_FREAD;
      8'h0A:   return CMD_PW;
      8'h02:   return CMD_PP;
      8'hDB:   return CMD_PE;
      8'hD8:   return CMD_SE;
      8'hB9:   return CMD_DP;
      8'hAB:   return CMD_RDP;
      default: return CMD_NONE;
    endcase
  endfunction

  // bytes (opcode included) before the output phase starts
  function automatic logic [2:0] hdr_len(input cmd_e c);
    case (c)
      CMD_READ:  return 3'd4;
      CMD_FREAD: return 3'd5;
      default:   return 3'd1;
    endcase
  endfunction

  function automatic logic touches_array(input cmd_e c);
    return c inside {CMD_READ, CMD_FREAD, CMD_PW, CMD_PP, CMD_PE, CMD_SE};
  endfunction

  function automatic logic framed(input cmd_e c);
    return c inside {CMD_PW, CMD_PP, CMD_PE, CMD_SE, CMD_WREN, CMD_WRDI,
                     CMD_DP, CMD_RDP};
  endfunction

  function automatic logic [2:0] min_bytes(input cmd_e c);
    case (c)
      CMD_PW, CMD_PP: return 3'd5;
      CMD_PE, CMD_SE: return 3'd4;
      default:        return 3'd1;
    endcase
  endfunction

  function automatic logic streams_out(input cmd_e c);
    return c inside {CMD_READ, CMD_FREAD, CMD_RDSR, CMD_RDID};
  endfunction

  function automatic logic [ADDR_W-1:0] page_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [7:0] off);
    return {base[ADDR_W-1:8], base[7:0] + off};
  endfunction

  function automatic logic [7:0] id_byte(input logic [23:0] id, input logic [1:0] idx);
    case (idx)
      2'd0:    return id[23:16];
      2'd1:    return id[15:8];
      2'd2:    return id[7:0];
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sfc_sync.sv
module sfc_sync #(
  parameter int         W   = 3,
  parameter int         N   = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stg [N];
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < N; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= RST;
      else        stg[i] <= stg[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= RST;
    else        prev <= stg[N-1];
  end

  assign q    = stg[N-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/sfc_txsr.sv
module sfc_txsr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       ld,
  input  logic       sh,
  input  logic [7:0] din,
  output logic       bit_o
);
  logic [7:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sr <= '0;
    else if (clr) sr <= '0;
    else if (ld)  sr <= din;
    else if (sh)  sr <= {sr[6:0], 1'b0};
  end

  assign bit_o = sr[7];
endmodule

// File: rtl/sflash_cmd_front.sv
module sflash_cmd_front
  import sfc_pkg::*;
#(
  parameter int          SYNC_N  = 2,
  parameter logic [23:0] ID_CODE = 24'hA5_3C_11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csn,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  input  logic              busy,
  input  logic [7:0]        stat_in,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [7:0]        rd_data,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              cmd_stb,
  output logic [3:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len
);
  localparam logic [LEN_W-1:0] LEN_SAT = LEN_W'(PAGE_MAX);
  localparam logic [2:0]       IDX_SAT = 3'd5;

  // synchronised pins: bit2 sck, bit1 csn, bit0 mosi
  logic [2:0] s_q, s_rise, s_fall;
  sfc_sync #(.W(3), .N(SYNC_N), .RST(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, csn, mosi}),
    .q(s_q), .rise(s_rise), .fall(s_fall)
  );
  wire unused_ok = &{1'b0, s_q[2], s_rise[0], s_fall[0]};

  // named events
  logic csn_s, mosi_s, sck_rise, sck_fall, cs_rise, cs_fall;
  assign csn_s    = s_q[1];
  assign mosi_s   = s_q[0];
  assign sck_rise = s_rise[2] & ~csn_s;
  assign sck_fall = s_fall[2] & ~csn_s;
  assign cs_rise  = s_rise[1];
  assign cs_fall  = s_fall[1];

  // transaction state
  logic [6:0]        sr;
  logic [2:0]        bitc;
  logic [2:0]        bidx;
  cmd_e              op;
  logic              blk;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        woff;
  logic [LEN_W-1:0]  dlen;
  logic              tx_act;
  logic [1:0]        out_idx;
  logic [7:0]        rd_buf;

  logic [7:0] byte_val;
  logic       byte_done;
  cmd_e       dec, cur;
  logic       blk_now;
  logic       frame_ok;
  logic       tx_ld, tx_sh;
  logic [7:0] tx_src;
  logic [ADDR_W-1:0] addr_next;

  assign byte_val  = {sr, mosi_s};
  assign byte_done = sck_rise && (bitc == 3'd7);
  assign dec       = op_decode(byte_val);
  assign cur       = (bidx == 3'd0) ? dec : op;
  assign blk_now   = (bidx == 3'd0) ? (busy && touches_array(dec)) : blk;
  assign addr_next = {addr[15:0], byte_val};
  assign frame_ok  = framed(op) && !blk && (bitc == 3'd0) && (bidx >= min_bytes(op));
  assign tx_ld     = sck_fall && tx_act && (bitc == 3'd0);
  assign tx_sh     = sck_fall && tx_act && (bitc != 3'd0);

  always_comb begin
    case (op)
      CMD_RDSR: tx_src = stat_in;
      CMD_RDID: tx_src = id_byte(ID_CODE, out_idx);
      default:  tx_src = rd_buf;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0; bitc <= '0; bidx <= '0; op <= CMD_NONE; blk <= 1'b0;
      addr <= '0; woff <= '0; dlen <= '0; tx_act <= 1'b0; out_idx <= '0;
      rd_buf <= '0; rd_req <= 1'b0; rd_addr <= '0;
      wr_valid <= 1'b0; wr_addr <= '0; wr_data <= '0;
      cmd_stb <= 1'b0; cmd_op <= '0; cmd_addr <= '0; cmd_len <= '0;
    end else begin
      cmd_stb  <= 1'b0;
      rd_req   <= 1'b0;
      wr_valid <= 1'b0;
      if (rd_valid) rd_buf <= rd_data;

      if (cs_fall) begin
        sr <= '0; bitc <= '0; bidx <= '0; op <= CMD_NONE; blk <= 1'b0;
        addr <= '0; woff <= '0; dlen <= '0; tx_act <= 1'b0; out_idx <= '0;
      end else if (cs_rise) begin
        cmd_stb <= frame_ok;
        if (frame_ok) begin
          cmd_op   <= op;
          cmd_addr <= addr;
          cmd_len  <= dlen;
        end
        tx_act <= 1'b0;
        op     <= CMD_NONE;
        blk    <= 1'b0;
      end else begin
        if (sck_rise) begin
          sr   <= byte_val[6:0];
          bitc <= bitc + 3'd1;
        end

        if (byte_done) begin
          if (bidx == 3'd0) begin
            op  <= dec;
            blk <= blk_now;
          end
          if (bidx >= 3'd1 && bidx <= 3'd3) addr <= addr_next;

          if (streams_out(cur) && !blk_now && (bidx + 3'd1 == hdr_len(cur))) begin
            tx_act <= 1'b1;
            if (cur == CMD_READ || cur == CMD_FREAD) begin
              rd_req  <= 1'b1;
              rd_addr <= (bidx == 3'd3) ? addr_next : addr;
            end
          end

          if ((cur == CMD_PW || cur == CMD_PP) && !blk_now && bidx >= 3'd4) begin
            wr_valid <= 1'b1;
            wr_addr  <= page_addr(addr, woff);
            wr_data  <= byte_val;
            woff     <= woff + 8'd1;
            if (dlen != LEN_SAT) dlen <= dlen + 1'b1;
          end

          if (bidx != IDX_SAT) bidx <= bidx + 3'd1;
        end

        if (tx_ld) begin
          if (out_idx != 2'd3) out_idx <= out_idx + 2'd1;
          if (op == CMD_READ || op == CMD_FREAD) begin
            rd_req  <= 1'b1;
            rd_addr <= rd_addr + 1'b1;
          end
        end
      end
    end
  end

  sfc_txsr u_tx (
    .clk(clk), .rst_n(rst_n), .clr(cs_fall), .ld(tx_ld), .sh(tx_sh),
    .din(tx_src), .bit_o(miso)
  );

  assign miso_oe = tx_act;
endmodule

// File: rtl/sfc_chk.sv
module sfc_chk
  import sfc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             csn_s,
  input logic             cs_rise,
  input logic [2:0]       bitc,
  input logic             blk,
  input logic             cmd_stb,
  input logic [3:0]       cmd_op,
  input logic [LEN_W-1:0] cmd_len,
  input logic             rd_req,
  input logic             wr_valid,
  input logic             miso_oe
);
  // R6: strobe only right after chip select rises, and only for one cycle
  a_r6_stb_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(cs_rise));
  a_r6_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  // R5: a strobe implies chip select rose on a byte boundary
  a_r5_byte_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> ($past(bitc) == 3'd0));

  // R9: nothing reaches the array while a transaction is blocked
  a_r9_no_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !$past(blk));
  a_r9_no_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !$past(blk));

  // R2: output enable drops once chip select is high
  a_r2_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !miso_oe);

  // R8: committed page length is within one page and nonzero
  a_r8_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && (cmd_op == 4'(CMD_PW) || cmd_op == 4'(CMD_PP)))
      |-> (cmd_len != '0 && cmd_len <= LEN_W'(PAGE_MAX)));
endmodule

bind sflash_cmd_front sfc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .cs_rise(cs_rise), .bitc(bitc),
  .blk(blk), .cmd_stb(cmd_stb), .cmd_op(cmd_op), .cmd_len(cmd_len),
  .rd_req(rd_req), .wr_valid(wr_valid), .miso_oe(miso_oe)
);

// File: tb/sim_sflash_cmd_front.sv
module sim_sflash_cmd_front;
  localparam int HALF = 8;
  localparam logic [23:0] ID = 24'hA5_3C_11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, busy = 1'b0;
  logic [7:0] stat_in = 8'h00;
  logic miso, miso_oe, rd_req, wr_valid, cmd_stb;
  logic rd_valid = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic [23:0] rd_addr, wr_addr, cmd_addr;
  logic [7:0] wr_data;
  logic [3:0] cmd_op;
  logic [8:0] cmd_len;

  always #10 clk = ~clk;

  sflash_cmd_front #(.ID_CODE(ID)) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .busy(busy), .stat_in(stat_in),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd_stb(cmd_stb), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len)
  );

  function automatic logic [7:0] mem_f(input logic [23:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ a[23:16] ^ 8'hC3;
  endfunction

  // back-end model
  always @(posedge clk) begin
    rd_valid <= rd_req;
    rd_data  <= mem_f(rd_addr);
  end

  // monitors
  int stb_cnt = 0, wr_cnt = 0, rd_cnt = 0, oe_cnt = 0;
  logic [3:0]  s_op;
  logic [23:0] s_addr;
  logic [8:0]  s_len;
  logic [31:0] wlog [0:511];
  always @(negedge clk) begin
    if (cmd_stb) begin stb_cnt++; s_op = cmd_op; s_addr = cmd_addr; s_len = cmd_len; end
    if (wr_valid) begin wlog[wr_cnt % 512] = {wr_addr, wr_data}; wr_cnt++; end
    if (rd_req) rd_cnt++;
    if (miso_oe) oe_cnt++;
  end

  int nvec = 0, nbad = 0;
  task automatic chk(input string tag, input longint got, input longint exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic sbit(input logic b, output logic r);
    @(negedge clk); mosi = b;
    repeat (HALF) @(negedge clk);
    r = miso; sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
    logic b;
    for (int i = 7; i >= 0; i--) begin sbit(t[i], b); r[i] = b; end
  endtask

  task automatic tx_bits(input logic [63:0] v, input int n);
    logic b;
    for (int i = 0; i < n; i++) sbit(v[63-i], b);
  endtask

  task automatic cs_lo;
    @(negedge clk); csn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_hi;
    repeat (HALF) @(negedge clk); csn = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  function automatic int exp_code(input logic [7:0] o);
    case (o)
      8'h06: return 1; 8'h04: return 2; 8'hB9: return 11; 8'hAB: return 12;
      default: return 0;
    endcase
  endfunction

  task automatic finish_run;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    int b0, w0, r0, o0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11 reset state
    chk("R11 oe", miso_oe, 0);
    chk("R11 strobes", stb_cnt, 0);
    chk("R11 reqs", rd_cnt + wr_cnt, 0);

    // R1 opcode sweep: only single-byte framed commands strobe
    for (int o = 0; o < 256; o++) begin
      b0 = stb_cnt;
      cs_lo(); tx_bits({8'(o), 56'h0}, 8); cs_hi();
      chk("R1 strobe count", stb_cnt - b0, exp_code(8'(o)) != 0 ? 1 : 0);
      if (exp_code(8'(o)) != 0) chk("R1 strobe code", s_op, exp_code(8'(o)));
      chk("R2 oe released", miso_oe, 0);
    end

    // R5 framing sweep on write enable: 1..17 pulses
    for (int n = 1; n <= 17; n++) begin
      b0 = stb_cnt;
      cs_lo(); tx_bits({8'h06, 56'hFF}, n); cs_hi();
      chk("R5 wren framing", stb_cnt - b0, (n % 8 == 0) ? 1 : 0);
    end
    b0 = stb_cnt;
    cs_lo(); cs_hi();
    chk("R5 zero pulses", stb_cnt - b0, 0);

    // R5/R6 framing sweep on page erase: 1..40 pulses
    for (int n = 1; n <= 40; n++) begin
      b0 = stb_cnt;
      cs_lo(); tx_bits({8'hDB, 24'h12_AB_CD, 32'h5555_5555}, n); cs_hi();
      chk("R5 erase framing", stb_cnt - b0, (n % 8 == 0 && n >= 32) ? 1 : 0);
      if (n == 32) begin
        chk("R6 erase addr", s_addr, 24'h12_AB_CD);
        chk("R1 erase code", s_op, 9);
      end
    end
    b0 = stb_cnt;
    cs_lo(); tx_bits({8'hD8, 24'h03_00_40, 32'h0}, 32); cs_hi();
    chk("R1 sector erase", stb_cnt - b0, 1);
    chk("R6 sector addr", s_addr, 24'h03_00_40);

    // R3 status
    stat_in = 8'h3C;
    o0 = oe_cnt;
    cs_lo(); xbyte(8'h05, r);
    xbyte(8'h00, r); chk("R3 status byte0", r, 8'h3C);
    xbyte(8'h00, r); chk("R3 status byte1", r, 8'h3C);
    cs_hi();
    chk("R2 oe during output", oe_cnt > o0, 1);
    chk("R2 oe after cs", miso_oe, 0);

    // R4 identification
    cs_lo(); xbyte(8'h9F, r);
    for (int i = 0; i < 4; i++) begin
      xbyte(8'h00, r);
      chk("R4 id byte", r, i < 3 ? (ID >> (8 * (2 - i))) & 8'hFF : 0);
    end
    cs_hi();

    // R7 read across a carry, then fast read
    cs_lo(); xbyte(8'h03, r); xbyte(8'h12, r); xbyte(8'h34, r); xbyte(8'hFE, r);
    for (int i = 0; i < 4; i++) begin
      xbyte(8'h00, r); chk("R7 read data", r, mem_f(24'h12_34_FE + 24'(i)));
    end
    cs_hi();
    cs_lo(); xbyte(8'h0B, r); xbyte(8'h00, r); xbyte(8'h80, r); xbyte(8'h07, r);
    xbyte(8'hAA, r);
    for (int i = 0; i < 3; i++) begin
      xbyte(8'h00, r); chk("R7 fast read data", r, mem_f(24'h00_80_07 + 24'(i)));
    end
    cs_hi();
    b0 = stb_cnt;
    cs_lo(); tx_bits({8'h03, 24'h00_00_10, 32'h0}, 35); cs_hi();
    chk("R7 abort no strobe", stb_cnt - b0, 0);
    chk("R7 abort oe", miso_oe, 0);

    // R8 page program wrapping inside the page
    b0 = stb_cnt; w0 = wr_cnt;
    cs_lo(); xbyte(8'h02, r); xbyte(8'h0A, r); xbyte(8'h0B, r); xbyte(8'hF0, r);
    for (int i = 0; i < 20; i++) xbyte(8'(i * 7 + 1), r);
    cs_hi();
    chk("R8 pp writes", wr_cnt - w0, 20);
    for (int i = 0; i < 20; i++)
      chk("R8 pp entry", wlog[(w0 + i) % 512],
          {16'h0A0B, 8'(8'hF0 + i), 8'(i * 7 + 1)});
    chk("R8 pp strobe", stb_cnt - b0, 1);
    chk("R1 pp code", s_op, 8);
    chk("R8 pp len", s_len, 20);
    chk("R6 pp addr", s_addr, 24'h0A_0B_F0);

    // R8 page write beyond one page
    b0 = stb_cnt; w0 = wr_cnt;
    cs_lo(); xbyte(8'h0A, r); xbyte(8'h00, r); xbyte(8'h00, r); xbyte(8'h10, r);
    for (int i = 0; i < 300; i++) xbyte(8'(i ^ 8'h5A), r);
    cs_hi();
    chk("R8 pw writes", wr_cnt - w0, 300);
    chk("R8 pw last entry", wlog[(w0 + 299) % 512], {16'h0000, 8'h3B, 8'(299 ^ 8'h5A)});
    chk("R8 pw len saturates", s_len, 256);
    chk("R1 pw code", s_op, 7);
    b0 = stb_cnt;
    cs_lo(); tx_bits({8'h02, 24'h000100, 32'h0}, 32); cs_hi();
    chk("R5 pp without data", stb_cnt - b0, 0);

    // R9 busy
    busy = 1'b1;
    b0 = stb_cnt; w0 = wr_cnt; r0 = rd_cnt; o0 = oe_cnt;
    cs_lo(); xbyte(8'h03, r); xbyte(8'h00, r); xbyte(8'h00, r); xbyte(8'h00, r);
    xbyte(8'h00, r); cs_hi();
    cs_lo(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h00, r); xbyte(8'h00, r);
    xbyte(8'h11, r); xbyte(8'h22, r); cs_hi();
    cs_lo(); tx_bits({8'hD8, 24'h0, 32'h0}, 32); cs_hi();
    chk("R9 busy no read", rd_cnt - r0, 0);
    chk("R9 busy no write", wr_cnt - w0, 0);
    chk("R9 busy no strobe", stb_cnt - b0, 0);
    chk("R9 busy no oe", oe_cnt - o0, 0);
    stat_in = 8'h81;
    cs_lo(); xbyte(8'h05, r); xbyte(8'h00, r); cs_hi();
    chk("R9 status while busy", r, 8'h81);
    cs_lo(); tx_bits({8'h06, 56'h0}, 8); cs_hi();
    chk("R9 wren while busy", stb_cnt - b0, 1);
    busy = 1'b0;

    // R10 unknown opcode
    b0 = stb_cnt; w0 = wr_cnt; r0 = rd_cnt; o0 = oe_cnt;
    cs_lo(); tx_bits({8'h77, 24'h01_02_03, 32'h0}, 32); cs_hi();
    chk("R10 unknown no oe", oe_cnt - o0, 0);
    chk("R10 unknown no strobe", stb_cnt - b0, 0);
    chk("R10 unknown no req", (rd_cnt - r0) + (wr_cnt - w0), 0);

    finish_run();
  end
endmodule